// File: doc/BRIEF.md
# Dual-Flag 24-bit ALU

This block is the combinational arithmetic and logic stage of a microcontroller whose registers are 24 bits wide. It takes a destination operand, a source operand, a 4-bit operation code and the current 8-bit flag word. It returns the 24-bit result, the new flag word, and a write-enable that says whether the result goes back to the destination register.

The flag word holds two sets of flags. The narrow set describes the result seen as a 16-bit value. The wide set describes the full 24-bit result. Arithmetic operations update both sets.

Logical operations and single-bit shifts or rotates work only on the low 16 bits. They pass the destination's upper byte through unchanged and leave the wide flag set as it was. A separate add variant, meant for address arithmetic, sign-extends an 8-bit source and changes no flags. Operand fetch, immediate decoding and register-file control are handled elsewhere.

Top module: `alu24_dual_flag`

## Requirements
- R1: The flag word is ordered, from bit 7 down to bit 0, as VX, CX, NX, ZX, V, C, N, Z. Whenever an operation updates them, N is result bit 15 and Z is set when result bits 15..0 are all zero. Whenever an operation updates them, NX is result bit 23 and ZX is set when the whole 24-bit result is zero.
- R2: Op code 0 (add) produces dst+src modulo 2^24. C is the carry out of bit 15 and CX is the carry out of bit 23. V and VX are signed overflow of the 16-bit and the 24-bit sum.
- R3: Op code 1 (add with carry) behaves as op code 0 but also adds the incoming C flag, flag word bit 2.
- R4: Op code 2 (subtract) produces dst-src modulo 2^24. C is the borrow out of the low 16 bits and CX is the borrow out of 24 bits. V and VX are signed overflow of the 16-bit and the 24-bit difference.
- R5: Op code 3 (subtract with borrow) behaves as op code 2 but also subtracts the incoming C flag.
- R6: Op code 4 (compare) produces the same eight flags as op code 2 and drives result_we low.
- R7: Op code 5 (AND) gives dst & (src | 0xFF0000), so the destination's upper byte passes through unchanged.
- R8: Op code 6 (OR) and op code 7 (XOR) combine dst with src & 0x00FFFF. Op code 8 (NOT) inverts only dst bits 15..0.
- R9: Op codes 5 to 8 clear V and C, set N and Z from the result, and leave VX, CX, NX and ZX at their incoming values.
- R10: Op code 9 (arithmetic shift right) keeps bit 15. Op code 10 (logical shift right) shifts a 0 into bit 15. Both act on dst bits 15..0, and bit 0 goes to C.
- R11: Op code 11 (rotate right) moves the incoming C into bit 15, and bit 0 goes to C. Op code 12 (rotate left) moves the incoming C into bit 0, and bit 15 goes to C.
- R12: Op codes 9 to 12 keep dst bits 23..16 and clear V. They set C, N and Z, and leave the four wide flags unchanged.
- R13: Op code 13 (add, no flags) produces dst plus the sign-extended src bits 7..0, modulo 2^24. It outputs the incoming flag word unchanged, with result_we high.
- R14: Op codes 14 and 15 are reserved. They output result equal to dst and the incoming flag word unchanged, with result_we low. Every other op code except 4 drives result_we high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dst_val | input | 24 | Destination operand (minuend for subtract and compare) |
| src_val | input | 24 | Source operand |
| op_sel | input | 4 | Operation code, see requirements |
| flags_in | input | 8 | Current flag word {VX,CX,NX,ZX,V,C,N,Z} |
| result | output | 24 | Operation result |
| flags_out | output | 8 | Updated flag word, same layout as flags_in |
| result_we | output | 1 | High when result is to be written to the destination |

## Verification
The hardest cases to reach are those where the narrow and wide flag sets disagree. In one, the carry comes out of bit 15 but not out of bit 23. In another, the only carry or borrow at bit 15 comes from the incoming C flag, because the low operand sum is exactly 0xFFFF or the low difference is exactly zero. Directed tasks build these operands by hand and set the incoming flag word explicitly. This includes a flag word whose wide bits are set and contradict the result, so that an operation wrongly touching the wide flags shows up at flags_out. A random sweep over all sixteen op codes, with random flag words, then covers the remaining combinations.

// File: rtl/alu24_pkg.sv
package alu24_pkg;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_ADDC  = 4'd1,
    OP_SUB   = 4'd2,
    OP_SUBC  = 4'd3,
    OP_CMP   = 4'd4,
    OP_AND   = 4'd5,
    OP_OR    = 4'd6,
    OP_XOR   = 4'd7,
    OP_NOT   = 4'd8,
    OP_ASR   = 4'd9,
    OP_LSR   = 4'd10,
    OP_ROR   = 4'd11,
    OP_ROL   = 4'd12,
    OP_ADDNF = 4'd13
  } alu_op_e;

  typedef struct packed {
    logic vx;
    logic cx;
    logic nx;
    logic zx;
    logic v;
    logic c;
    logic n;
    logic z;
  } flag_word_t;

  // Signed overflow of a + b_eff, judged from the sign bits alone.
  function automatic logic sign_overflow(input logic a_msb, input logic b_msb,
                                         input logic s_msb);
    return (a_msb == b_msb) && (s_msb != a_msb);
  endfunction

  function automatic logic is_arith_op(input logic [3:0] op);
    return (op == OP_ADD) || (op == OP_ADDC) || (op == OP_SUB) ||
           (op == OP_SUBC) || (op == OP_CMP);
  endfunction

  function automatic logic is_sub_op(input logic [3:0] op);
    return (op == OP_SUB) || (op == OP_SUBC) || (op == OP_CMP);
  endfunction

  function automatic logic is_logic_op(input logic [3:0] op);
    return (op >= OP_AND) && (op <= OP_NOT);
  endfunction

  function automatic logic is_shift_op(input logic [3:0] op);
    return (op >= OP_ASR) && (op <= OP_ROL);
  endfunction

endpackage

// File: rtl/alu24_addsub.sv
module alu24_addsub #(
  parameter int DATA_W   = 24,
  parameter int NARROW_W = 16
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  input  logic              cin,
  output logic [DATA_W-1:0] sum,
  output logic              c_lo,
  output logic              c_hi,
  output logic              v_lo,
  output logic              v_hi
);
  import alu24_pkg::*;

  logic [DATA_W-1:0] b_eff;
  logic              c_inj;
  logic [NARROW_W:0] lo_sum;
  logic [DATA_W:0]   full_sum;

  // Subtract as a + ~b + ~borrow; carry becomes not-borrow.
  assign b_eff    = sub ? ~b : b;
  assign c_inj    = sub ? ~cin : cin;
  assign lo_sum   = {1'b0, a[NARROW_W-1:0]} + {1'b0, b_eff[NARROW_W-1:0]} +
                    {{NARROW_W{1'b0}}, c_inj};
  assign full_sum = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, c_inj};
  assign sum      = full_sum[DATA_W-1:0];

  assign c_lo = sub ? ~lo_sum[NARROW_W] : lo_sum[NARROW_W];
  assign c_hi = sub ? ~full_sum[DATA_W] : full_sum[DATA_W];
  assign v_lo = sign_overflow(a[NARROW_W-1], b_eff[NARROW_W-1], sum[NARROW_W-1]);
  assign v_hi = sign_overflow(a[DATA_W-1], b_eff[DATA_W-1], sum[DATA_W-1]);

  always_comb begin
    // R2
    lo_carry_wrap_chk: assert (sub || cin ||
                               (c_lo == (sum[NARROW_W-1:0] < a[NARROW_W-1:0])));
    // R4
    lo_borrow_order_chk: assert (!sub || cin ||
                                 (c_lo == (a[NARROW_W-1:0] < b[NARROW_W-1:0])));
  end

endmodule

// File: rtl/alu24_logic.sv
module alu24_logic #(
  parameter int NARROW_W = 16
) (
  input  logic [3:0]          op,
  input  logic [NARROW_W-1:0] a,
  input  logic [NARROW_W-1:0] b,
  output logic [NARROW_W-1:0] y
);
  import alu24_pkg::*;

  always_comb begin
    unique case (op)
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_NOT:  y = ~a;
      default: y = a;
    endcase
  end

  always_comb begin
    // R8
    not_involution_chk: assert (op != OP_NOT || ((y ^ a) == {NARROW_W{1'b1}}));
  end

endmodule

// File: rtl/alu24_shift.sv
module alu24_shift #(
  parameter int NARROW_W = 16
) (
  input  logic [3:0]          op,
  input  logic [NARROW_W-1:0] a,
  input  logic                cin,
  output logic [NARROW_W-1:0] y,
  output logic                cout
);
  import alu24_pkg::*;

  logic is_left;
  logic fill_bit;

  assign is_left = (op == OP_ROL);

  always_comb begin
    unique case (op)
      OP_ASR:  fill_bit = a[NARROW_W-1];
      OP_LSR:  fill_bit = 1'b0;
      default: fill_bit = cin;
    endcase
  end

  always_comb begin
    if (is_left) begin
      y    = {a[NARROW_W-2:0], fill_bit};
      cout = a[NARROW_W-1];
    end else begin
      y    = {fill_bit, a[NARROW_W-1:1]};
      cout = a[0];
    end
  end

  always_comb begin
    // R11
    rotate_keeps_ones_chk: assert (!(op == OP_ROR || op == OP_ROL) ||
                                   ($countones({y, cout}) == $countones({a, cin})));
    // R10
    asr_sign_keep_chk: assert (op != OP_ASR || (y[NARROW_W-1] == a[NARROW_W-1]));
  end

endmodule

// File: rtl/alu24_dual_flag.sv
module alu24_dual_flag #(
  parameter int DATA_W   = 24,
  parameter int NARROW_W = 16,
  parameter int IMM_W    = 8
) (
  input  logic [DATA_W-1:0] dst_val,
  input  logic [DATA_W-1:0] src_val,
  input  logic [3:0]        op_sel,
  input  logic [7:0]        flags_in,
  output logic [DATA_W-1:0] result,
  output logic [7:0]        flags_out,
  output logic              result_we
);
  import alu24_pkg::*;

  localparam int UPPER_W = DATA_W - NARROW_W;
  localparam int EXT_W   = DATA_W - IMM_W;

  flag_word_t fin;
  flag_word_t fout;

  logic op_arith, op_sub, op_logic, op_shift, op_addnf, op_carry;

  logic [DATA_W-1:0]   as_b;
  logic [DATA_W-1:0]   as_sum;
  logic                as_c_lo, as_c_hi, as_v_lo, as_v_hi;
  logic [NARROW_W-1:0] lg_y;
  logic [NARROW_W-1:0] sh_y;
  logic                sh_cout;
  logic                res_n_lo, res_z_lo, res_n_hi, res_z_hi;

  assign fin       = flag_word_t'(flags_in);
  assign flags_out = fout;

  assign op_arith = is_arith_op(op_sel);
  assign op_sub   = is_sub_op(op_sel);
  assign op_logic = is_logic_op(op_sel);
  assign op_shift = is_shift_op(op_sel);
  assign op_addnf = (op_sel == OP_ADDNF);
  assign op_carry = (op_sel == OP_ADDC) || (op_sel == OP_SUBC);

  assign as_b = op_addnf ? {{EXT_W{src_val[IMM_W-1]}}, src_val[IMM_W-1:0]} : src_val;

  alu24_addsub #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_addsub (
    .a    (dst_val),
    .b    (as_b),
    .sub  (op_sub),
    .cin  (op_carry & fin.c),
    .sum  (as_sum),
    .c_lo (as_c_lo),
    .c_hi (as_c_hi),
    .v_lo (as_v_lo),
    .v_hi (as_v_hi)
  );

  alu24_logic #(.NARROW_W(NARROW_W)) u_logic (
    .op (op_sel),
    .a  (dst_val[NARROW_W-1:0]),
    .b  (src_val[NARROW_W-1:0]),
    .y  (lg_y)
  );

  alu24_shift #(.NARROW_W(NARROW_W)) u_shift (
    .op   (op_sel),
    .a    (dst_val[NARROW_W-1:0]),
    .cin  (fin.c),
    .y    (sh_y),
    .cout (sh_cout)
  );

  always_comb begin
    if (op_arith || op_addnf)  result = as_sum;
    else if (op_logic)         result = {dst_val[DATA_W-1:NARROW_W], lg_y};
    else if (op_shift)         result = {dst_val[DATA_W-1:NARROW_W], sh_y};
    else                       result = dst_val;
  end

  assign result_we = (op_sel != OP_CMP) && (op_arith || op_logic || op_shift || op_addnf);

  assign res_n_lo = result[NARROW_W-1];
  assign res_z_lo = ~|result[NARROW_W-1:0];
  assign res_n_hi = result[DATA_W-1];
  assign res_z_hi = ~|result;

  always_comb begin
    fout = fin;
    if (op_arith) begin
      fout.vx = as_v_hi;
      fout.cx = as_c_hi;
      fout.nx = res_n_hi;
      fout.zx = res_z_hi;
      fout.v  = as_v_lo;
      fout.c  = as_c_lo;
      fout.n  = res_n_lo;
      fout.z  = res_z_lo;
    end else if (op_logic || op_shift) begin
      fout.v  = 1'b0;
      fout.c  = op_shift ? sh_cout : 1'b0;
      fout.n  = res_n_lo;
      fout.z  = res_z_lo;
    end
  end

  always_comb begin
    // R7
    upper_byte_pass_chk: assert (!(op_logic || op_shift) ||
                                 (result[DATA_W-1:NARROW_W] == dst_val[DATA_W-1:NARROW_W]));
    // R9
    wide_flags_hold_chk: assert (!(op_logic || op_shift) ||
                                 (flags_out[7:4] == flags_in[7:4]));
    // R6
    compare_no_write_chk: assert (op_sel != OP_CMP || !result_we);
    // R13
    quiet_flags_chk: assert (!(op_addnf || op_sel > OP_ADDNF) || (flags_out == flags_in));
    // R1
    wide_zero_implies_narrow_chk: assert (!op_arith || !fout.zx || fout.z);
    // R12
    narrow_ops_no_overflow_chk: assert (!(op_logic || op_shift) || !fout.v);
    // R14
    reserved_idle_chk: assert (!(op_sel > OP_ADDNF) || (!result_we && result == dst_val));
  end

  if (UPPER_W < 1) begin : g_bad_widths
    initial $fatal(1, "DATA_W must exceed NARROW_W");
  end

endmodule

// File: tb/test_alu24_dual_flag.sv
module test_alu24_dual_flag;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [23:0] dst_val, src_val;
  logic [3:0]  op_sel;
  logic [7:0]  flags_in;
  logic [23:0] result;
  logic [7:0]  flags_out;
  logic        result_we;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;
  logic [31:0] lfsr = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu24_dual_flag i_alu24_dual_flag (
    .dst_val  (dst_val),
    .src_val  (src_val),
    .op_sel   (op_sel),
    .flags_in (flags_in),
    .result   (result),
    .flags_out(flags_out),
    .result_we(result_we)
  );

  // Reference: returns {we, flags[7:0], result[23:0]}
  function automatic logic [32:0] ref_model(input logic [3:0] op, input logic [23:0] d,
                                            input logic [23:0] s, input logic [7:0] f);
    logic [23:0] r;
    logic [7:0]  fl;
    logic        we;
    longint      cin, full, lo, sv16, sv24;
    logic        v, c, vx, cx;
    r = d; fl = f; we = 1'b1;
    if (op <= 4'd4) begin
      cin = (op == 4'd1 || op == 4'd3) ? longint'(f[2]) : 0;
      if (op == 4'd0 || op == 4'd1) begin
        full = longint'(d) + longint'(s) + cin;
        lo   = longint'(d[15:0]) + longint'(s[15:0]) + cin;
        sv16 = longint'($signed(d[15:0])) + longint'($signed(s[15:0])) + cin;
        sv24 = longint'($signed(d)) + longint'($signed(s)) + cin;
        cx = full > 64'sd16777215;
        c  = lo > 64'sd65535;
      end else begin
        full = longint'(d) - longint'(s) - cin;
        lo   = longint'(d[15:0]) - longint'(s[15:0]) - cin;
        sv16 = longint'($signed(d[15:0])) - longint'($signed(s[15:0])) - cin;
        sv24 = longint'($signed(d)) - longint'($signed(s)) - cin;
        cx = full < 0;
        c  = lo < 0;
      end
      v  = (sv16 > 32767) || (sv16 < -32768);
      vx = (sv24 > 8388607) || (sv24 < -8388608);
      r  = full[23:0];
      fl = {vx, cx, r[23], r == 24'd0, v, c, r[15], r[15:0] == 16'd0};
      we = (op != 4'd4);
    end else if (op <= 4'd8) begin
      case (op)
        4'd5: r = d & (s | 24'hFF0000);
        4'd6: r = d | (s & 24'h00FFFF);
        4'd7: r = d ^ (s & 24'h00FFFF);
        default: r = d ^ 24'h00FFFF;
      endcase
      fl = {f[7:4], 1'b0, 1'b0, r[15], r[15:0] == 16'd0};
    end else if (op <= 4'd12) begin
      case (op)
        4'd9:  begin r = {d[23:16], d[15], d[15:1]}; c = d[0];  end
        4'd10: begin r = {d[23:16], 1'b0, d[15:1]};  c = d[0];  end
        4'd11: begin r = {d[23:16], f[2], d[15:1]};  c = d[0];  end
        default: begin r = {d[23:16], d[14:0], f[2]}; c = d[15]; end
      endcase
      fl = {f[7:4], 1'b0, c, r[15], r[15:0] == 16'd0};
    end else if (op == 4'd13) begin
      r = d + {{16{s[7]}}, s[7:0]};
    end else begin
      we = 1'b0;
    end
    return {we, fl, r};
  endfunction

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd0: return "R2";  4'd1: return "R3";  4'd2: return "R4";  4'd3: return "R5";
      4'd4: return "R6";  4'd5: return "R7";  4'd6, 4'd7, 4'd8: return "R8";
      4'd9, 4'd10: return "R10"; 4'd11, 4'd12: return "R11";
      4'd13: return "R13"; default: return "R14";
    endcase
  endfunction

  task automatic chk(input string req, input logic [3:0] op, input logic [23:0] d,
                     input logic [23:0] s, input logic [7:0] f);
    logic [32:0] exp_v;
    exp_v = ref_model(op, d, s, f);
    @(posedge clk);
    op_sel = op; dst_val = d; src_val = s; flags_in = f;
    @(negedge clk);
    checks++;
    if ({result_we, flags_out, result} !== exp_v) begin
      failures++;
      $display("FAIL %s op=%0d d=%h s=%h f=%b: got we=%b flags=%b res=%h exp we=%b flags=%b res=%h",
               req, op, d, s, f, result_we, flags_out, result,
               exp_v[32], exp_v[31:24], exp_v[23:0]);
    end
  endtask

  task automatic t_reset_state;
    // R1: all-zero inputs give an add of zero, both zero flags set
    chk("R1", 4'd0, 24'h0, 24'h0, 8'h00);
  endtask

  task automatic t_add;
    chk("R2", 4'd0, 24'h007FFF, 24'h000001, 8'h00);
    chk("R2", 4'd0, 24'h00FFFF, 24'h000001, 8'h00);
    chk("R2", 4'd0, 24'h7FFFFF, 24'h000001, 8'h00);
    chk("R2", 4'd0, 24'hFFFFFF, 24'h000001, 8'h00);
    chk("R1", 4'd0, 24'h018000, 24'h008000, 8'h00);
  endtask

  task automatic t_addc;
    chk("R3", 4'd1, 24'h00FFFE, 24'h000001, 8'h04);
    chk("R3", 4'd1, 24'hFFFFFE, 24'h000001, 8'h04);
    chk("R3", 4'd1, 24'h001234, 24'h000000, 8'hFB);
  endtask

  task automatic t_sub;
    chk("R4", 4'd2, 24'h008000, 24'h000001, 8'h00);
    chk("R4", 4'd2, 24'h000000, 24'h000001, 8'h00);
    chk("R4", 4'd2, 24'h800000, 24'h000001, 8'h00);
    chk("R4", 4'd2, 24'h010000, 24'h000001, 8'h00);
  endtask

  task automatic t_subc;
    chk("R5", 4'd3, 24'h000001, 24'h000001, 8'h04);
    chk("R5", 4'd3, 24'h123456, 24'h123456, 8'h00);
  endtask

  task automatic t_cmp;
    chk("R6", 4'd4, 24'h7FFFFF, 24'hFFFFFF, 8'h00);
    chk("R6", 4'd4, 24'hABCDEF, 24'hABCDEF, 8'hFF);
  endtask

  task automatic t_logic;
    chk("R7", 4'd5, 24'hA5FFFF, 24'h00F00F, 8'hF0);
    chk("R8", 4'd6, 24'h120000, 24'hFF8000, 8'h00);
    chk("R8", 4'd7, 24'h34FFFF, 24'hFFFFFF, 8'h0F);
    chk("R8", 4'd8, 24'h56FFFF, 24'h000000, 8'hA5);
    chk("R9", 4'd5, 24'h000000, 24'hFFFFFF, 8'hFF);
  endtask

  task automatic t_shift;
    chk("R10", 4'd9,  24'hAA8001, 24'h0, 8'h00);
    chk("R10", 4'd10, 24'hAA8001, 24'h0, 8'hF0);
    chk("R11", 4'd11, 24'h550002, 24'h0, 8'h04);
    chk("R11", 4'd12, 24'h558000, 24'h0, 8'h00);
    chk("R12", 4'd10, 24'hFF0001, 24'h0, 8'h5F);
  endtask

  task automatic t_addnf;
    chk("R13", 4'd13, 24'h001000, 24'hFFFF80, 8'hA5);
    chk("R13", 4'd13, 24'hFFFFFF, 24'h00007F, 8'h00);
  endtask

  task automatic t_reserved;
    chk("R14", 4'd14, 24'h123456, 24'h654321, 8'h3C);
    chk("R14", 4'd15, 24'hFFFFFF, 24'h000001, 8'hC3);
  endtask

  function automatic logic [31:0] step(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    return y ^ (y << 5);
  endfunction

  task automatic t_random;
    logic [23:0] d, s;
    logic [7:0]  f;
    for (int i = 0; i < 300; i++) begin
      for (int op = 0; op < 16; op++) begin
        lfsr = step(lfsr); d = lfsr[23:0]; f = lfsr[31:24];
        lfsr = step(lfsr); s = lfsr[23:0];
        chk(req_of(4'(op)), 4'(op), d, s, f);
      end
    end
  endtask

  initial begin
    op_sel = 4'd0; dst_val = '0; src_val = '0; flags_in = '0;
    t_reset_state();
    t_add();
    t_addc();
    t_sub();
    t_subc();
    t_cmp();
    t_logic();
    t_shift();
    t_addnf();
    t_reserved();
    t_random();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule